// File: doc/BRIEF.md
# Interleaved Two-Level LL and Line-Buffer Address Controller

This block sits beside a line-based 2-D wavelet engine that works on two decomposition levels in turns rather than finishing one level before starting the next. It does no arithmetic. Its job is to decide which level is active and to produce the storage addresses that level needs.

Each level has its own column line-buffer region of four lines. Each level also has its own LL-band region, used as a circular buffer with its own read pointer, write pointer and fill count. The engine presents one coefficient per cycle on `coef_valid`/`coef_data`. The controller stores it in the active level's LL region, gives the matching line-buffer address, and counts it toward the level switch. Reads from the active LL region are requested on `rd_req`.

After a fixed number of coefficients, the active level flips. The state of the level being left stays untouched in its own registers, so that level resumes exactly where it stopped.

Top module: `ll_level_ctrl`

## Requirements
- R1: After reset the active level is 0, both LL regions are empty, both line-buffer positions are at line 0 column 0, and `ll_wr_en`, `ll_rd_en`, `overflow` and `lb_en` are low while the inputs are idle.
- R2: Every cycle with `coef_valid` high counts, whether or not the coefficient is stored. On the cycle after the 4096th counted coefficient, `active_lvl` toggles. Level 0 is the first decomposition level (lines 128 wide) and level 1 is the second (lines 64 wide).
- R3: A coefficient arriving while the active LL region is not full drives `ll_wr_en` high in the same cycle.
  - `ll_wr_data` equals `coef_data`.
  - `ll_wr_addr` is the region base plus the write pointer.
  - Level 0 owns words 0 to 1535 (12 lines of 128). Level 1 owns words 1536 to 2815 (20 lines of 64).
  - The pointer wraps to the region start after the region's last word.
- R4: A coefficient arriving while the active region holds its full capacity of unread words raises `overflow` for that cycle. It writes nothing and leaves the write pointer as it was. Fullness is judged before any read in the same cycle.
- R5: `rd_req` while the active region holds unread data drives `ll_rd_en` high, with `ll_rd_addr` equal to the region base plus the read pointer. The read pointer then advances with the same wrap as R3. `rd_req` on an empty region leaves `ll_rd_en` low and changes nothing.
- R6: Every cycle with `coef_valid` high drives `lb_en` high.
  - `lb_addr` is the line-buffer base plus line × width plus column.
  - Level 0 has base 0 and width 128. Level 1 has base 512 and width 64.
  - The column advances on each coefficient. At the end of a line, the line index steps through 0, 1, 2, 3 and back to 0.
- R7: A level switch neither clears nor moves any pointer, fill count or line-buffer position of either level. The resumed level's next write, read and line-buffer addresses continue from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| coef_valid | input | 1 | Coefficient present this cycle |
| coef_data | input | 11 | Coefficient value |
| rd_req | input | 1 | Request to read the active LL region |
| active_lvl | output | 1 | Level currently served (0 or 1) |
| ll_wr_en | output | 1 | LL memory write strobe |
| ll_wr_addr | output | 12 | LL memory write address |
| ll_wr_data | output | 11 | LL memory write data |
| ll_rd_en | output | 1 | LL memory read strobe |
| ll_rd_addr | output | 12 | LL memory read address |
| lb_en | output | 1 | Line-buffer access strobe |
| lb_addr | output | 10 | Line-buffer address |
| overflow | output | 1 | Coefficient dropped because the active LL region is full |

## Verification
The hardest situation to reach from the ports is a level resuming with non-trivial saved state: part-filled LL data, a wrapped write pointer and a mid-line column. It only appears after thousands of coefficients at each level.

The stimulus gets there in three steps:
- It fills level 0 to overflow, drains a few words and lets the write pointer wrap.
- It runs level 1 through a full switch period of mixed writes and reads, overflowing it as well.
- It returns to level 0 and checks every address against a model of the requirements, cycle by cycle.

// File: rtl/ll_level_ctrl.sv
module ll_level_ctrl #(
  parameter int DW          = 11,
  parameter int L0_W        = 128,
  parameter int L1_W        = 64,
  parameter int LB_LINES    = 4,
  parameter int L0_LL_LINES = 12,
  parameter int L1_LL_LINES = 20,
  parameter int SWITCH_N    = 4096
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 coef_valid,
  input  logic [DW-1:0]        coef_data,
  input  logic                 rd_req,
  output logic                 active_lvl,
  output logic                 ll_wr_en,
  output logic [11:0]          ll_wr_addr,
  output logic [DW-1:0]        ll_wr_data,
  output logic                 ll_rd_en,
  output logic [11:0]          ll_rd_addr,
  output logic                 lb_en,
  output logic [9:0]           lb_addr,
  output logic                 overflow
);
  localparam int L0_DEPTH = L0_W * L0_LL_LINES;
  localparam int L1_DEPTH = L1_W * L1_LL_LINES;
  localparam int LL_AW    = 12;
  localparam int LB_AW    = 10;
  localparam int PW       = $clog2((L0_DEPTH > L1_DEPTH ? L0_DEPTH : L1_DEPTH) + 1);
  localparam int CW       = $clog2(L0_W > L1_W ? L0_W : L1_W);
  localparam int RW       = $clog2(LB_LINES);
  localparam int SW       = $clog2(SWITCH_N);

  logic [PW-1:0] wr_ptr [2];
  logic [PW-1:0] rd_ptr [2];
  logic [PW-1:0] fill   [2];
  logic [CW-1:0] col    [2];
  logic [RW-1:0] row    [2];
  logic [SW-1:0] sw_cnt;
  logic          lvl;

  logic [PW-1:0] depth;
  logic [CW-1:0] col_last;
  logic          full, empty, do_wr, do_rd;

  assign depth    = lvl ? PW'(L1_DEPTH) : PW'(L0_DEPTH);
  assign col_last = lvl ? CW'(L1_W - 1) : CW'(L0_W - 1);
  assign full     = fill[lvl] == depth;
  assign empty    = fill[lvl] == '0;
  assign do_wr    = coef_valid & ~full;
  assign do_rd    = rd_req & ~empty;

  assign active_lvl = lvl;
  assign ll_wr_en   = do_wr;
  assign ll_wr_data = coef_data;
  assign ll_rd_en   = do_rd;
  assign overflow   = coef_valid & full;
  assign lb_en      = coef_valid;

  assign ll_wr_addr = (lvl ? LL_AW'(L0_DEPTH) : '0) + LL_AW'(wr_ptr[lvl]);
  assign ll_rd_addr = (lvl ? LL_AW'(L0_DEPTH) : '0) + LL_AW'(rd_ptr[lvl]);
  assign lb_addr    = (lvl ? LB_AW'(LB_LINES * L0_W) : '0)
                    + LB_AW'(row[lvl]) * (lvl ? LB_AW'(L1_W) : LB_AW'(L0_W))
                    + LB_AW'(col[lvl]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        wr_ptr[i] <= '0;
        rd_ptr[i] <= '0;
        fill[i]   <= '0;
        col[i]    <= '0;
        row[i]    <= '0;
      end
      sw_cnt <= '0;
      lvl    <= 1'b0;
    end else begin
      if (do_wr)
        wr_ptr[lvl] <= (wr_ptr[lvl] == depth - 1'b1) ? '0 : wr_ptr[lvl] + 1'b1;
      if (do_rd)
        rd_ptr[lvl] <= (rd_ptr[lvl] == depth - 1'b1) ? '0 : rd_ptr[lvl] + 1'b1;
      fill[lvl] <= fill[lvl] + PW'(do_wr) - PW'(do_rd);
      if (coef_valid) begin
        if (col[lvl] == col_last) begin
          col[lvl] <= '0;
          row[lvl] <= (row[lvl] == RW'(LB_LINES - 1)) ? '0 : row[lvl] + 1'b1;
        end else begin
          col[lvl] <= col[lvl] + 1'b1;
        end
        if (sw_cnt == SW'(SWITCH_N - 1)) begin
          sw_cnt <= '0;
          lvl    <= ~lvl;
        end else begin
          sw_cnt <= sw_cnt + 1'b1;
        end
      end
    end
  end

  a_r3_wr_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    ll_wr_en |-> (active_lvl ? (ll_wr_addr >= LL_AW'(L0_DEPTH) &&
                                ll_wr_addr <  LL_AW'(L0_DEPTH + L1_DEPTH))
                             : (ll_wr_addr < LL_AW'(L0_DEPTH))));

  a_r4_no_overflow_write: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !ll_wr_en);

  a_r2_switch_needs_coef: assert property (@(posedge clk) disable iff (!rst_n)
    (active_lvl != $past(active_lvl)) |-> $past(coef_valid));

  a_r5_read_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    ll_rd_en |-> rd_req);

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!coef_valid && !rd_req) |=> ($stable(ll_wr_addr) && $stable(ll_rd_addr) &&
                                  $stable(active_lvl)));

  a_r6_lb_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    lb_en |-> (active_lvl ? (lb_addr >= LB_AW'(LB_LINES * L0_W) &&
                             lb_addr <  LB_AW'(LB_LINES * (L0_W + L1_W)))
                          : (lb_addr < LB_AW'(LB_LINES * L0_W))));
endmodule

// File: tb/tb_ll_level_ctrl.sv
module tb_ll_level_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coef_valid = 1'b0;
  logic [10:0] coef_data = '0;
  logic rd_req = 1'b0;
  logic active_lvl, ll_wr_en, ll_rd_en, lb_en, overflow;
  logic [11:0] ll_wr_addr, ll_rd_addr;
  logic [10:0] ll_wr_data;
  logic [9:0] lb_addr;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  ll_level_ctrl dut (.*);

  // {v, r, we, wa[12], re, ra[12], le, la[10]} from reset, level 0
  localparam logic [38:0] VEC [6] = '{
    {1'b1, 1'b0, 1'b1, 12'd0, 1'b0, 12'd0, 1'b1, 10'd0},
    {1'b1, 1'b1, 1'b1, 12'd1, 1'b1, 12'd0, 1'b1, 10'd1},
    {1'b0, 1'b1, 1'b0, 12'd0, 1'b1, 12'd1, 1'b0, 10'd0},
    {1'b0, 1'b1, 1'b0, 12'd0, 1'b0, 12'd0, 1'b0, 10'd0},
    {1'b1, 1'b1, 1'b1, 12'd2, 1'b0, 12'd0, 1'b1, 10'd2},
    {1'b0, 1'b1, 1'b0, 12'd0, 1'b1, 12'd2, 1'b0, 10'd0}
  };

  int m_lvl, m_sw, switched;
  int m_wr[2], m_rd[2], m_fill[2], m_col[2], m_row[2];
  int D[2] = '{1536, 1280};
  int W[2] = '{128, 64};
  int LLB[2] = '{0, 1536};
  int LBB[2] = '{0, 512};

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    m_lvl = 0; m_sw = 0;
    for (int i = 0; i < 2; i++) begin
      m_wr[i] = 0; m_rd[i] = 0; m_fill[i] = 0; m_col[i] = 0; m_row[i] = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; coef_valid = 1'b0; rd_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    switched = 0;
  endtask

  task automatic step(bit v, bit r);
    bit full, we, re;
    string at;
    @(negedge clk);
    coef_valid = v; rd_req = r; coef_data = 11'(cyc * 7 + 3);
    #5;
    at = switched ? "R7" : "R3";
    full = m_fill[m_lvl] == D[m_lvl];
    we = v && !full;
    re = r && m_fill[m_lvl] != 0;
    chk("R2 active_lvl", active_lvl, m_lvl);
    chk("R3 ll_wr_en", ll_wr_en, we);
    chk("R4 overflow", overflow, v && full);
    if (we) begin
      chk({at, " ll_wr_addr"}, ll_wr_addr, LLB[m_lvl] + m_wr[m_lvl]);
      chk("R3 ll_wr_data", ll_wr_data, coef_data);
    end
    chk("R5 ll_rd_en", ll_rd_en, re);
    if (re) chk(switched ? "R7 ll_rd_addr" : "R5 ll_rd_addr", ll_rd_addr, LLB[m_lvl] + m_rd[m_lvl]);
    chk("R6 lb_en", lb_en, v);
    if (v) chk(switched ? "R7 lb_addr" : "R6 lb_addr", lb_addr,
               LBB[m_lvl] + m_row[m_lvl] * W[m_lvl] + m_col[m_lvl]);
    if (we) begin m_wr[m_lvl] = (m_wr[m_lvl] + 1) % D[m_lvl]; m_fill[m_lvl]++; end
    if (re) begin m_rd[m_lvl] = (m_rd[m_lvl] + 1) % D[m_lvl]; m_fill[m_lvl]--; end
    if (v) begin
      m_col[m_lvl]++;
      if (m_col[m_lvl] == W[m_lvl]) begin m_col[m_lvl] = 0; m_row[m_lvl] = (m_row[m_lvl] + 1) % 4; end
      m_sw++;
      if (m_sw == 4096) begin m_sw = 0; m_lvl ^= 1; switched = 1; end
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1: idle outputs after reset
    #5;
    chk("R1 active_lvl", active_lvl, 0);
    chk("R1 ll_wr_en", ll_wr_en, 0);
    chk("R1 ll_rd_en", ll_rd_en, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 lb_en", lb_en, 0);

    // vector table walk (R3 R5 R6 basics)
    for (int k = 0; k < 6; k++) begin
      logic [38:0] e;
      e = VEC[k];
      @(negedge clk);
      coef_valid = e[38]; rd_req = e[37]; coef_data = 11'(k + 100);
      #5;
      chk("R3 vec ll_wr_en", ll_wr_en, e[36]);
      if (e[36]) chk("R3 vec ll_wr_addr", ll_wr_addr, e[35:24]);
      chk("R5 vec ll_rd_en", ll_rd_en, e[23]);
      if (e[23]) chk("R5 vec ll_rd_addr", ll_rd_addr, e[22:11]);
      chk("R6 vec lb_en", lb_en, e[10]);
      if (e[10]) chk("R6 vec lb_addr", lb_addr, e[9:0]);
    end

    // R1: read on empty region after reset
    do_reset();
    step(0, 1);

    // R4: fill level 0, then overflow, including write+read on full
    for (int k = 0; k < 1536; k++) step(1, 0);
    step(1, 0);
    step(1, 1);
    for (int k = 0; k < 3; k++) step(0, 1);
    // R3: write pointer wraps to region start
    for (int k = 0; k < 5; k++) step(1, 0);
    // continue to the switch (R2)
    while (!switched) step(1, (cyc % 3) == 0);
    // level 1: mixed traffic, then overflow, then switch back (R2 R4 R7)
    for (int k = 0; k < 300; k++) step(1, (k % 2) == 0);
    while (m_lvl == 1) step(1, (cyc % 5) == 0);
    // R7: level 0 resumes with saved state
    for (int k = 0; k < 40; k++) step(k % 2 == 0, 1);
    for (int k = 0; k < 10; k++) step(0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule